// File: doc/BRIEF.md
# GPIO port with change interrupt

This block is an eight-pin general-purpose I/O port controlled over a small register bus. Each pin has a direction bit and an output latch bit. A pin whose direction bit is clear drives its latch value onto the pad. A pin whose direction bit is set is tri-stated and read as an input. Pad inputs pass through a two-flop synchronizer before any logic uses them. A single active-low control bit turns on weak pull-ups. The lower pins can be placed in analog mode, where they read as zero and lose their pull-up.

The upper four pins watch for input changes. Each participating pin is compared with a snapshot taken at the last port read, and any difference sets a sticky change flag. Software clears the flag by first reading the port, which refreshes the snapshot, and then writing a clear one cycle or more later. The flag, gated by an enable bit, drives a single interrupt/wake request line. That line is a plain combinational output, so it can serve as a wake source while the core is stopped.

Top module: `gpio_chg_port`

## Requirements
- R1: After reset: pad_oe = 0x00, pad_out = 0x00, pad_pu = 0x00, irq_wake = 0. The registers read as follows: latch (addr 1) 0x00, direction (addr 2) 0xFF, analog (addr 3) 0x0F, control (addr 4) 0x01.
- R2: For each pin i, pad_oe[i] is 1 exactly when direction bit i is 0, and pad_out equals the output latch.
- R3: A write to addr 0 or addr 1 loads the output latch. A read of addr 1 returns the latch whatever the pad levels are.
- R4: A read of addr 0 returns pad_in as sampled two clock edges earlier. Lower pins (bits 3:0) whose analog bit (addr 3, bits 3:0) is 1 read as 0.
- R5: pad_pu[i] is 1 exactly when control bit 0 is 0, direction bit i is 1, and pin i is not in analog mode.
- R6: The change flag (control bit 2) sets when a synchronized input on bits 7:4 with direction bit 1 differs from the snapshot taken at the last read of addr 0. Bits 3:0 and output pins never set it.
- R7: While a mismatch exists, a clear request (write to addr 4 with bit 2 = 1) leaves the flag set.
- R8: A clear request in the same cycle as a port read, or in the cycle right after one, leaves the flag set. A clear request two or more cycles after the read clears the flag.
- R9: irq_wake equals the flag ANDed with the interrupt enable (control bit 1). The flag still sets when the enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| pad_in | input | 8 | Asynchronous pad levels |
| pad_out | output | 8 | Output data to pads |
| pad_oe | output | 8 | Per-pin output enable |
| pad_pu | output | 8 | Per-pin weak pull-up enable |
| irq_wake | output | 1 | Interrupt / wake request |

## Verification
Register writes show on pad_oe, pad_out and pad_pu after the single edge that takes the write, so the bench samples them at the following falling edge. Read data is combinational, but the pin value behind it lags pad_in by two edges. The bench therefore reads once after one edge and once after two, expecting the old value and then the new one. A pin change sets the flag on the third edge, and the bench waits four cycles before it looks. The clear-window tests place the clear write back-to-back with the port read, and then one idle cycle later, and compare the flag read back after each.

// File: rtl/gpio_pkg.sv
// Shared register addresses and control bit positions for the GPIO port.
package gpio_pkg;
    typedef enum logic [2:0] {
        A_PORT = 3'd0,
        A_LAT  = 3'd1,
        A_DIR  = 3'd2,
        A_ANA  = 3'd3,
        A_CTRL = 3'd4
    } reg_addr_e;

    localparam int CTRL_PUN  = 0;  // active-low pull-up enable
    localparam int CTRL_IE   = 1;  // interrupt enable
    localparam int CTRL_FLAG = 2;  // change flag (read) / clear (write 1)
endpackage

// File: rtl/gpio_sync.sv
// Multi-stage synchronizer for the asynchronous pad inputs.
// Assumes STAGES >= 1; all stages clear to zero on reset.
module gpio_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] synced
);
    logic [W-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stg
        if (s == 0) begin : g_first
            // capture the raw pad level
            always_ff @(posedge clk) begin
                if (!rst_n) stg[0] <= '0;
                else        stg[0] <= raw;
            end
        end else begin : g_next
            // shift through the later stages
            always_ff @(posedge clk) begin
                if (!rst_n) stg[s] <= '0;
                else        stg[s] <= stg[s-1];
            end
        end
    end

    assign synced = stg[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
// Holds the latch, direction, analog and control registers and the read mux.
// It also derives the pad output enables and pull-up enables.
// Assumes ANA_PINS <= W and one bus access per cycle.
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int W        = 8,
    parameter int ANA_PINS = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bus_rd,
    input  logic         bus_wr,
    input  logic [2:0]   bus_addr,
    input  logic [W-1:0] bus_wdata,
    output logic [W-1:0] bus_rdata,
    input  logic [W-1:0] pins_sync,
    input  logic         flag,
    output logic [W-1:0] lat,
    output logic [W-1:0] dir,
    output logic         ie,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] pad_pu
);
    localparam int HI_PINS = W - ANA_PINS;

    logic [ANA_PINS-1:0] ana;
    logic                pu_n;
    logic [W-1:0]        ana_mask;
    logic [W-1:0]        pin_val;
    reg_addr_e           addr;

    assign addr     = reg_addr_e'(bus_addr);
    assign ana_mask = {{HI_PINS{1'b0}}, ana};
    assign pin_val  = pins_sync & ~ana_mask;

    // register writes; writes to the port address load the latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat  <= '0;
            dir  <= '1;
            ana  <= '1;
            pu_n <= 1'b1;
            ie   <= 1'b0;
        end else if (bus_wr) begin
            case (addr)
                A_PORT, A_LAT: lat <= bus_wdata;
                A_DIR:         dir <= bus_wdata;
                A_ANA:         ana <= bus_wdata[ANA_PINS-1:0];
                A_CTRL: begin
                    pu_n <= bus_wdata[CTRL_PUN];
                    ie   <= bus_wdata[CTRL_IE];
                end
                default: ;
            endcase
        end
    end

    // read data selection
    always_comb begin
        bus_rdata = '0;
        case (addr)
            A_PORT: bus_rdata = pin_val;
            A_LAT:  bus_rdata = lat;
            A_DIR:  bus_rdata = dir;
            A_ANA:  bus_rdata = ana_mask;
            A_CTRL: begin
                bus_rdata[CTRL_PUN]  = pu_n;
                bus_rdata[CTRL_IE]   = ie;
                bus_rdata[CTRL_FLAG] = flag;
            end
            default: bus_rdata = '0;
        endcase
    end

    // pad drive and pull-up enables
    always_comb begin
        pad_oe = ~dir;
        pad_pu = {W{~pu_n}} & dir & ~ana_mask;
    end

    // R4
    ana_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && addr == A_PORT) |-> ((bus_rdata[ANA_PINS-1:0] & ana) == '0));

    // R5
    pu_off_when_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pu & pad_oe) == '0);
endmodule

// File: rtl/gpio_chg.sv
// Change detector for the upper pins. The snapshot is refreshed on every port
// read, and the flag is sticky. A clear is refused while a mismatch exists,
// and in the read cycle and the cycle after it.
// Assumes the inputs are already synchronized.
module gpio_chg #(
    parameter int W  = 8,
    parameter int LO = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [W-LO-1:0] pins_hi,
    input  logic [W-LO-1:0] dir_hi,
    input  logic           port_rd,
    input  logic           clr_req,
    output logic           flag
);
    logic [W-LO-1:0] snap;
    logic            mismatch;
    logic            rd_dly;
    logic            clr_ok;

    assign mismatch = |((pins_hi ^ snap) & dir_hi);
    assign clr_ok   = clr_req && !mismatch && !port_rd && !rd_dly;

    // snapshot and read-delay tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap   <= '0;
            rd_dly <= 1'b0;
        end else begin
            if (port_rd) snap <= pins_hi;
            rd_dly <= port_rd;
        end
    end

    // sticky flag; setting wins over clearing
    always_ff @(posedge clk) begin
        if (!rst_n)        flag <= 1'b0;
        else if (mismatch) flag <= 1'b1;
        else if (clr_ok)   flag <= 1'b0;
    end

    // R6
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mismatch |=> flag);

    // R8
    clr_blocked_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && port_rd) |=> flag);

    // R8
    clr_blocked_dly_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && rd_dly) |=> flag);
endmodule

// File: rtl/gpio_chg_port.sv
// Top level of the GPIO port: pad synchronizer, register file and change
// detector, plus the gated interrupt/wake request.
// Assumes single-cycle bus strobes and that rd and wr are never both high.
module gpio_chg_port
    import gpio_pkg::*;
#(
    parameter int W          = 8,
    parameter int ANA_PINS   = 4,
    parameter int CHG_LO     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bus_rd,
    input  logic         bus_wr,
    input  logic [2:0]   bus_addr,
    input  logic [W-1:0] bus_wdata,
    output logic [W-1:0] bus_rdata,
    input  logic [W-1:0] pad_in,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] pad_pu,
    output logic         irq_wake
);
    logic [W-1:0] pins_sync;
    logic [W-1:0] lat;
    logic [W-1:0] dir;
    logic         ie;
    logic         flag;
    logic         port_rd;
    logic         clr_req;

    assign port_rd = bus_rd && (bus_addr == A_PORT);
    assign clr_req = bus_wr && (bus_addr == A_CTRL) && bus_wdata[CTRL_FLAG];

    gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw    (pad_in),
        .synced (pins_sync)
    );

    gpio_regs #(.W(W), .ANA_PINS(ANA_PINS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pins_sync (pins_sync),
        .flag      (flag),
        .lat       (lat),
        .dir       (dir),
        .ie        (ie),
        .pad_oe    (pad_oe),
        .pad_pu    (pad_pu)
    );

    gpio_chg #(.W(W), .LO(CHG_LO)) u_chg (
        .clk     (clk),
        .rst_n   (rst_n),
        .pins_hi (pins_sync[W-1:CHG_LO]),
        .dir_hi  (dir[W-1:CHG_LO]),
        .port_rd (port_rd),
        .clr_req (clr_req),
        .flag    (flag)
    );

    assign pad_out  = lat;
    assign irq_wake = flag & ie;

    // R2
    oe_matches_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_wr && bus_addr == A_DIR) |-> (pad_oe == ~$past(bus_wdata)));
endmodule

// File: tb/gpio_chg_port_test.sv
module gpio_chg_port_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic [7:0] pad_in = 8'd0;
    logic [7:0] pad_out, pad_oe, pad_pu;
    logic       irq_wake;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    gpio_chg_port uut (
        .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .pad_pu(pad_pu), .irq_wake(irq_wake)
    );

    // vector: dir, lat, ana, pu_n, exp_oe, exp_out, exp_pu
    localparam logic [55:0] VEC [5] = '{
        56'hFF_00_0F_00_00_00_F0,
        56'h00_A5_00_00_FF_A5_00,
        56'h0F_3C_03_00_F0_3C_0C,
        56'hCF_FF_00_00_30_FF_CF,
        56'hCF_12_00_01_30_12_00
    };

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // called at a falling edge; returns at the next one
    task automatic bus_write(logic [2:0] a, logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic [2:0] a, output logic [7:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin : watchdog
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (done) disable watchdog;
        end
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0] r;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        check("R1 oe", pad_oe, 8'h00);
        check("R1 out", pad_out, 8'h00);
        check("R1 pu", pad_pu, 8'h00);
        check("R1 irq", {7'd0, irq_wake}, 8'h00);
        bus_read(3'd1, r); check("R1 lat", r, 8'h00);
        bus_read(3'd2, r); check("R1 dir", r, 8'hFF);
        bus_read(3'd3, r); check("R1 ana", r, 8'h0F);
        bus_read(3'd4, r); check("R1 ctrl", r, 8'h01);

        // R2 R5 vector table
        foreach (VEC[k]) begin
            bus_write(3'd2, VEC[k][55:48]);
            bus_write(3'd1, VEC[k][47:40]);
            bus_write(3'd3, VEC[k][39:32]);
            bus_write(3'd4, VEC[k][31:24]);
            check("R2 oe", pad_oe, VEC[k][23:16]);
            check("R2 out", pad_out, VEC[k][15:8]);
            check("R5 pu", pad_pu, VEC[k][7:0]);
        end

        // R3 latch access, independent of pads
        bus_write(3'd2, 8'hFF);
        bus_write(3'd4, 8'h01);
        pad_in = 8'hF0;
        bus_write(3'd0, 8'h3C);
        bus_read(3'd1, r); check("R3 lat via port write", r, 8'h3C);
        bus_write(3'd1, 8'h81);
        bus_read(3'd1, r); check("R3 lat", r, 8'h81);
        check("R3 pad_out", pad_out, 8'h81);

        // R4 analog masking and sync delay
        bus_write(3'd3, 8'h0F);
        pad_in = 8'hA5;
        idle(3);
        bus_read(3'd0, r); check("R4 analog masked", r, 8'hA0);
        bus_write(3'd3, 8'h00);
        bus_read(3'd0, r); check("R4 digital", r, 8'hA5);
        pad_in = 8'h5A;
        idle(1);
        bus_read(3'd0, r); check("R4 one edge old", r, 8'hA5);
        bus_read(3'd0, r); check("R4 two edges new", r, 8'h5A);

        // set snapshot to 00
        pad_in = 8'h00;
        idle(3);
        bus_read(3'd0, r);
        idle(1);
        bus_write(3'd4, 8'h05);
        bus_read(3'd4, r); check("R6 flag idle", r & 8'h04, 8'h00);

        // R6 R9 change on bit 4, interrupt disabled
        pad_in = 8'h10;
        idle(4);
        bus_read(3'd4, r); check("R6 flag set", r & 8'h04, 8'h04);
        check("R9 irq gated", {7'd0, irq_wake}, 8'h00);

        // R7 clear during mismatch
        bus_write(3'd4, 8'h05);
        bus_read(3'd4, r); check("R7 clear refused", r & 8'h04, 8'h04);

        // R8 clear right after read refused, later accepted
        bus_read(3'd0, r);
        bus_write(3'd4, 8'h05);
        bus_read(3'd4, r); check("R8 clear after read refused", r & 8'h04, 8'h04);
        bus_write(3'd4, 8'h05);
        bus_read(3'd4, r); check("R8 later clear", r & 8'h04, 8'h00);

        // R6 lower pin change ignored
        pad_in = 8'h11;
        idle(4);
        bus_read(3'd4, r); check("R6 low pin ignored", r & 8'h04, 8'h00);

        // R6 output pin excluded
        bus_write(3'd2, 8'hEF);
        pad_in = 8'h01;
        idle(4);
        bus_read(3'd4, r); check("R6 output excluded", r & 8'h04, 8'h00);
        bus_write(3'd2, 8'hFF);
        idle(1);
        bus_read(3'd4, r); check("R6 input again", r & 8'h04, 8'h04);

        // R9 enable
        bus_write(3'd4, 8'h03);
        check("R9 irq on", {7'd0, irq_wake}, 8'h01);
        bus_read(3'd0, r);
        idle(1);
        bus_write(3'd4, 8'h07);
        check("R9 irq off after clear", {7'd0, irq_wake}, 8'h00);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule